// File: doc/BRIEF.md
# CCM and CMAC Phase Sequencer

This block is the staging and control logic that sits in front of an AES-128 cipher engine used for CCM or CMAC authenticated processing. Software pushes 32-bit words through a write port into an input FIFO of eight entries. The sequencer collects four words into a 128-bit block and hands the block to an external cipher through a request/acknowledge handshake. Where the current phase produces output, it returns the four result words through an output FIFO that software drains through a read port. The AES rounds, B0/B1 block formatting, tag comparison and DMA all stay outside the block.

A 2-bit phase field selects the stage: 2'b00 initialisation, 2'b01 header, 2'b10 payload and 2'b11 final (tag). Initialisation and header blocks are consumed by the engine and produce no output. Payload and final blocks each yield four output words. In the final phase, software writes the counter block A0 as four words and reads back the four-word encrypted tag. Software may move straight from the header phase to the final phase while the enable stays set. In CMAC mode the payload phase is never entered: while the phase field reads payload, no block is started.

The sequencer has five states. S_IDLE is held while the enable is low. S_WAIT holds until a block can start. S_GATHER pops four words, one per cycle. S_REQ holds the cipher request until acknowledge. S_PUSH writes four result words, one per cycle. The transitions are:
- S_IDLE to S_WAIT when the block is enabled.
- S_WAIT to S_GATHER when there is enough input, enough output room, and no CMAC hold.
- S_GATHER to S_REQ after the fourth pop.
- S_REQ to S_PUSH on acknowledge in an emitting phase, or S_REQ to S_WAIT on acknowledge in a silent phase.
- S_PUSH to S_WAIT after the fourth push.
- Any state to S_IDLE when the enable drops.

Top module: `ccm_phase_seq`

## Requirements
- R1: After reset the input-empty and input-not-full flags are 1, the output-not-empty, output-full and error flags are 0, and no cipher request is raised.
- R2: Four consecutive input words form one block, and the first word written becomes bits 127:96 of `eng_din`. Results are returned in the same order, with bits 127:96 of `eng_dout` read out first.
- R3: A block started with phase code 2'b00 or 2'b01 goes to the engine and adds nothing to the output FIFO. A block started with phase code 2'b10 or 2'b11 adds four words to it. `eng_phase` carries the phase code that was captured when the block started.
- R4: `eng_dir` carries the direction bit (1 = decrypt) that was captured when the block started, so each payload block uses the direction set before it began.
- R5: When `cfg_cmac` is 1 and the phase is 2'b10, no block is started, and words written stay in the input FIFO.
- R6: The input FIFO holds IN_DEPTH (8) words. `sts_in_not_full` is 0 exactly when it is full, and `sts_in_empty` is 1 exactly when it holds nothing.
- R7: The output FIFO holds OUT_DEPTH (8) words. `sts_out_not_empty` and `sts_out_full` reflect its fill level.
- R8: A block starts only when at least four words are in the input FIFO and at least four entries are free in the output FIFO.
- R9: While the block is enabled, a write to a full input FIFO or a read from an empty output FIFO is ignored and sets `sts_err`. `sts_err` stays set until the enable is cleared.
- R10: Clearing `cfg_en` empties both FIFOs, drops `eng_req` on the next cycle, abandons the block in flight, clears `sts_err` and returns to S_IDLE. Writes and reads made while disabled are ignored and raise no error.
- R11: Changing the phase from 2'b01 to 2'b11 with `cfg_en` held at 1 processes the next block as a tag block, without a disable/enable cycle.
- R12: `eng_req` stays high with `eng_din` stable until `eng_ack` is seen, unless the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable; low flushes and idles |
| cfg_phase | input | 2 | Phase code: 00 init, 01 header, 10 payload, 11 final |
| cfg_dir | input | 1 | Direction, 0 encrypt, 1 decrypt |
| cfg_cmac | input | 1 | CMAC mode: payload phase is held off |
| wr_en | input | 1 | Write strobe into the input FIFO |
| wr_data | input | 32 | Write data word |
| rd_en | input | 1 | Read strobe from the output FIFO |
| rd_data | output | 32 | Head word of the output FIFO (0 when empty) |
| sts_in_not_full | output | 1 | Input FIFO can take a word |
| sts_in_empty | output | 1 | Input FIFO is empty |
| sts_out_not_empty | output | 1 | Output FIFO holds data |
| sts_out_full | output | 1 | Output FIFO is full |
| sts_err | output | 1 | Sticky access error |
| eng_req | output | 1 | Cipher request |
| eng_phase | output | 2 | Phase code of the block in flight |
| eng_dir | output | 1 | Direction of the block in flight |
| eng_din | output | 128 | Block handed to the cipher |
| eng_ack | input | 1 | Cipher result valid, one cycle |
| eng_dout | input | 128 | Cipher result block |

## Verification
The bench builds the block with its default depths of eight words on each side. With that depth, two queued tag blocks fill the output FIFO exactly, which makes the four-free-entries start gate observable when a third block waits in the input FIFO. The ninth write in the held CMAC payload phase lands on a full input FIFO. The engine stub's acknowledge delay is varied, including one long enough to abandon a request mid-flight by clearing the enable.

// File: rtl/ccm_seq_pkg.sv
package ccm_seq_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;

    typedef enum logic [1:0] {
        PH_INIT    = 2'b00,
        PH_HEADER  = 2'b01,
        PH_PAYLOAD = 2'b10,
        PH_FINAL   = 2'b11
    } phase_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_GATHER,
        S_REQ,
        S_PUSH
    } seq_state_t;

    // Payload and final blocks return data; init and header blocks do not.
    function automatic logic phase_emits(input phase_t ph);
        return (ph == PH_PAYLOAD) || (ph == PH_FINAL);
    endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import ccm_seq_pkg::*;
#(
    parameter  int IN_DEPTH  = 8,
    parameter  int OUT_DEPTH = 8,
    localparam int ICW       = $clog2(IN_DEPTH + 1),
    localparam int OCW       = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        phase,
    input  logic              dir,
    input  logic              cmac,
    input  logic [ICW-1:0]    in_count,
    input  logic [OCW-1:0]    out_count,
    input  logic [WORD_W-1:0] in_head,
    output logic              in_pop,
    output logic              out_push,
    output logic [WORD_W-1:0] out_word,
    output logic              eng_req,
    output logic [1:0]        eng_phase,
    output logic              eng_dir,
    output logic [BLK_W-1:0]  eng_din,
    input  logic              eng_ack,
    input  logic [BLK_W-1:0]  eng_dout
);

    localparam int              BEAT_W    = $clog2(BLK_WORDS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLK_WORDS - 1);

    seq_state_t        state, state_n;
    logic [BEAT_W-1:0] beat;
    logic [BLK_W-1:0]  blk, res;
    phase_t            blk_phase;
    logic              blk_dir;
    logic              enough_in, enough_room, cmac_hold, start;

    // Start gate: a whole block waiting, room for a whole result, no CMAC hold.
    always_comb begin
        enough_in   = int'(in_count) >= BLK_WORDS;
        enough_room = (OUT_DEPTH - int'(out_count)) >= BLK_WORDS;
        cmac_hold   = cmac && (phase == PH_PAYLOAD);
        start       = enough_in && enough_room && !cmac_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (en) state_n = S_WAIT;
            S_WAIT:   if (start) state_n = S_GATHER;
            S_GATHER: if (beat == LAST_BEAT) state_n = S_REQ;
            S_REQ:    if (eng_ack) state_n = phase_emits(blk_phase) ? S_PUSH : S_WAIT;
            S_PUSH:   if (beat == LAST_BEAT) state_n = S_WAIT;
            default:  state_n = S_IDLE;
        endcase
        if (!en) begin
            state_n = S_IDLE;
        end
    end

    always_comb begin
        in_pop   = 1'b0;
        out_push = 1'b0;
        eng_req  = 1'b0;
        unique case (state)
            S_GATHER: in_pop   = 1'b1;
            S_REQ:    eng_req  = 1'b1;
            S_PUSH:   out_push = 1'b1;
            default:  ;
        endcase
        eng_din   = blk;
        eng_phase = blk_phase;
        eng_dir   = blk_dir;
        out_word  = res[BLK_W-1 -: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat      <= '0;
            blk       <= '0;
            res       <= '0;
            blk_phase <= PH_INIT;
            blk_dir   <= 1'b0;
        end else begin
            if (state != state_n) begin
                beat <= '0;
            end else if (in_pop || out_push) begin
                beat <= beat + 1'b1;
            end
            if (state == S_WAIT && state_n == S_GATHER) begin
                blk_phase <= phase_t'(phase);
                blk_dir   <= dir;
            end
            if (in_pop) begin
                blk <= {blk[BLK_W-WORD_W-1:0], in_head};
            end
            if (state == S_REQ && eng_ack) begin
                res <= eng_dout;
            end else if (out_push) begin
                res <= {res[BLK_W-WORD_W-1:0], {WORD_W{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/ccm_phase_seq.sv
module ccm_phase_seq
    import ccm_seq_pkg::*;
#(
    parameter int IN_DEPTH  = 8,
    parameter int OUT_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_phase,
    input  logic          cfg_dir,
    input  logic          cfg_cmac,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    output logic [31:0]   rd_data,
    output logic          sts_in_not_full,
    output logic          sts_in_empty,
    output logic          sts_out_not_empty,
    output logic          sts_out_full,
    output logic          sts_err,
    output logic          eng_req,
    output logic [1:0]    eng_phase,
    output logic          eng_dir,
    output logic [127:0]  eng_din,
    input  logic          eng_ack,
    input  logic [127:0]  eng_dout
);

    localparam int ICW = $clog2(IN_DEPTH + 1);
    localparam int OCW = $clog2(OUT_DEPTH + 1);

    logic [ICW-1:0]    in_count;
    logic [OCW-1:0]    out_count;
    logic [WORD_W-1:0] in_head, out_head, out_word;
    logic              in_full, in_empty, out_full, out_empty;
    logic              in_pop, out_push;

    seq_fifo #(.W(WORD_W), .DEPTH(IN_DEPTH)) u_in_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!cfg_en),
        .push      (wr_en && cfg_en),
        .push_data (wr_data),
        .pop       (in_pop),
        .head      (in_head),
        .count     (in_count),
        .full      (in_full),
        .empty     (in_empty)
    );

    seq_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!cfg_en),
        .push      (out_push),
        .push_data (out_word),
        .pop       (rd_en && cfg_en),
        .head      (out_head),
        .count     (out_count),
        .full      (out_full),
        .empty     (out_empty)
    );

    seq_ctrl #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .phase     (cfg_phase),
        .dir       (cfg_dir),
        .cmac      (cfg_cmac),
        .in_count  (in_count),
        .out_count (out_count),
        .in_head   (in_head),
        .in_pop    (in_pop),
        .out_push  (out_push),
        .out_word  (out_word),
        .eng_req   (eng_req),
        .eng_phase (eng_phase),
        .eng_dir   (eng_dir),
        .eng_din   (eng_din),
        .eng_ack   (eng_ack),
        .eng_dout  (eng_dout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_err <= 1'b0;
        end else if (!cfg_en) begin
            sts_err <= 1'b0;
        end else if ((wr_en && in_full) || (rd_en && out_empty)) begin
            sts_err <= 1'b1;
        end
    end

    assign rd_data           = out_empty ? '0 : out_head;
    assign sts_in_not_full   = !in_full;
    assign sts_in_empty      = in_empty;
    assign sts_out_not_empty = !out_empty;
    assign sts_out_full      = out_full;

endmodule

// File: rtl/ccm_phase_seq_chk.sv
module ccm_phase_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_en,
    input logic         eng_req,
    input logic         eng_ack,
    input logic [127:0] eng_din,
    input logic         sts_in_empty,
    input logic         sts_in_not_full,
    input logic         sts_out_not_empty,
    input logic         sts_err
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && cfg_en) |=> eng_req);  // R12

    AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && cfg_en) |=> $stable(eng_din));  // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_err && cfg_en) |=> sts_err);  // R9

    AST_IDLE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!eng_req && sts_in_empty && !sts_out_not_empty && !sts_err));  // R10

    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        sts_in_empty |-> sts_in_not_full);  // R6

endmodule

bind ccm_phase_seq ccm_phase_seq_chk u_chk (.*);

// File: tb/ccm_phase_seq_test.sv
`timescale 1ns/1ps
module ccm_phase_seq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0;
    logic [1:0]   cfg_phase = 2'b00;
    logic         cfg_dir = 1'b0;
    logic         cfg_cmac = 1'b0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [31:0]  rd_data;
    logic         sts_in_not_full, sts_in_empty, sts_out_not_empty, sts_out_full, sts_err;
    logic         eng_req, eng_dir;
    logic [1:0]   eng_phase;
    logic [127:0] eng_din;
    logic         eng_ack = 1'b0;
    logic [127:0] eng_dout = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ccm_phase_seq uut (.*);

    function automatic logic [127:0] cipher_f(input logic [127:0] d, input logic [1:0] ph, input logic dr);
        return {d[95:0], d[127:96]} ^ {4{{28'h3C96A5F, dr, 1'b0, ph}}};
    endfunction

    // Engine stub with programmable latency
    int           eng_delay = 2;
    int           stub_st = 0;
    int           stub_cnt = 0;
    int           req_count = 0;
    logic [127:0] last_din = '0;
    logic [1:0]   last_phase = '0;
    logic         last_dir = 1'b0;

    always @(posedge clk) begin
        eng_ack <= 1'b0;
        if (!rst_n || !eng_req) begin
            stub_st <= 0;
        end else if (stub_st == 0) begin
            stub_cnt <= eng_delay;
            stub_st  <= 1;
        end else if (stub_st == 1) begin
            if (stub_cnt == 0) begin
                eng_ack    <= 1'b1;
                eng_dout   <= cipher_f(eng_din, eng_phase, eng_dir);
                last_din   <= eng_din;
                last_phase <= eng_phase;
                last_dir   <= eng_dir;
                req_count  <= req_count + 1;
                stub_st    <= 2;
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(input string req, output logic [31:0] w);
        int t;
        t = 0;
        @(negedge clk);
        while (!sts_out_not_empty && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!sts_out_not_empty) begin
            total++;
            bad++;
            $display("FAIL %s actual=empty expected=data", req);
        end
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_block(input string req, input logic [127:0] exp);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            read_word(req, w);
            check(req, w, exp[127 - 32*i -: 32]);
        end
    endtask

    task automatic write_block(input logic [127:0] b, input int gap);
        for (int i = 0; i < 4; i++) begin
            write_word(b[127 - 32*i -: 32]);
            if (gap > 0) idle($urandom % (gap + 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] blk_a, blk_b, blk_c;
        logic [127:0] rb [2];
        logic [31:0]  w;
        int           base, seed_val;

        seed_val = $urandom(32'd20240611);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 in_empty", 32'(sts_in_empty), 32'd1);
        check("R1 in_not_full", 32'(sts_in_not_full), 32'd1);
        check("R1 out_not_empty", 32'(sts_out_not_empty), 32'd0);
        check("R1 out_full", 32'(sts_out_full), 32'd0);
        check("R1 err", 32'(sts_err), 32'd0);
        check("R1 req", 32'(eng_req), 32'd0);

        // R3 header block: goes to the engine, no output
        cfg_en = 1'b1;
        cfg_phase = 2'b01;
        idle(2);
        blk_a = {32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004};
        base = req_count;
        write_block(blk_a, 0);
        idle(30);
        check("R3 header req count", 32'(req_count - base), 32'd1);
        check("R3 header no output", 32'(sts_out_not_empty), 32'd0);
        check("R3 header phase", 32'(last_phase), 32'd1);
        check("R2 word order w0", last_din[127:96], 32'h1111_0001);
        check("R2 word order w3", last_din[31:0], 32'h4444_0004);
        check("R6 in empty after block", 32'(sts_in_empty), 32'd1);

        // R11 header to final without re-enable; A0 block returns the tag
        cfg_phase = 2'b11;
        blk_b = {32'hA0A0_0000, 32'h0000_0001, 32'hDEAD_BEEF, 32'h0123_4567};
        write_block(blk_b, 1);
        read_block("R11 tag word", cipher_f(blk_b, 2'b11, cfg_dir));
        check("R3 final phase", 32'(last_phase), 32'd3);

        // R2 R3 R4 random payload blocks, one or two per round
        cfg_phase = 2'b10;
        for (int r = 0; r < 14; r++) begin
            int nb;
            nb = 1 + ($urandom % 2);
            @(negedge clk);
            cfg_dir = 1'($urandom % 2);
            eng_delay = $urandom % 6;
            for (int b = 0; b < nb; b++) begin
                rb[b] = {$urandom, $urandom, $urandom, $urandom};
                write_block(rb[b], 2);
            end
            for (int b = 0; b < nb; b++) begin
                read_block("R2 R4 payload word", cipher_f(rb[b], 2'b10, cfg_dir));
            end
            check("R4 engine dir", 32'(last_dir), 32'(cfg_dir));
        end
        eng_delay = 2;

        // R5 CMAC holds the payload phase; R6 full input; R9 overflow write
        cfg_cmac = 1'b1;
        cfg_dir = 1'b0;
        blk_a = {32'hC0C0_0001, 32'hC0C0_0002, 32'hC0C0_0003, 32'hC0C0_0004};
        blk_b = {32'hD0D0_0001, 32'hD0D0_0002, 32'hD0D0_0003, 32'hD0D0_0004};
        base = req_count;
        write_block(blk_a, 0);
        idle(30);
        check("R5 cmac no start", 32'(req_count - base), 32'd0);
        check("R5 cmac words kept", 32'(sts_in_empty), 32'd0);
        write_block(blk_b, 0);
        idle(2);
        check("R6 in full", 32'(sts_in_not_full), 32'd0);
        check("R9 no err yet", 32'(sts_err), 32'd0);
        write_word(32'hBAD0_BAD0);
        idle(1);
        check("R9 overflow err", 32'(sts_err), 32'd1);
        cfg_phase = 2'b11;
        read_block("R5 cmac tag first", cipher_f(blk_a, 2'b11, 1'b0));
        read_block("R5 cmac tag second", cipher_f(blk_b, 2'b11, 1'b0));
        idle(20);
        check("R9 ignored write", 32'(sts_in_empty), 32'd1);
        check("R9 ignored write out", 32'(sts_out_not_empty), 32'd0);
        check("R9 err sticky", 32'(sts_err), 32'd1);

        // R10 disable clears error; R9 read from empty output
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_cmac = 1'b0;
        idle(2);
        check("R10 err cleared", 32'(sts_err), 32'd0);
        @(negedge clk);
        cfg_en = 1'b1;
        idle(2);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 underflow err", 32'(sts_err), 32'd1);
        @(negedge clk);
        cfg_en = 1'b0;
        idle(2);

        // R7 R8 output full blocks the third block until room appears
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_phase = 2'b11;
        idle(2);
        blk_a = {$urandom, $urandom, $urandom, $urandom};
        blk_b = {$urandom, $urandom, $urandom, $urandom};
        blk_c = {$urandom, $urandom, $urandom, $urandom};
        base = req_count;
        write_block(blk_a, 0);
        write_block(blk_b, 0);
        idle(40);
        check("R7 out full", 32'(sts_out_full), 32'd1);
        check("R7 out not empty", 32'(sts_out_not_empty), 32'd1);
        write_block(blk_c, 0);
        idle(40);
        check("R8 third held", 32'(req_count - base), 32'd2);
        check("R8 input kept", 32'(sts_in_empty), 32'd0);
        read_block("R8 first tag", cipher_f(blk_a, 2'b11, 1'b0));
        read_block("R8 second tag", cipher_f(blk_b, 2'b11, 1'b0));
        read_block("R8 third tag", cipher_f(blk_c, 2'b11, 1'b0));
        check("R8 third ran", 32'(req_count - base), 32'd3);

        // R10 abort while a request is waiting
        eng_delay = 60;
        cfg_phase = 2'b10;
        base = req_count;
        write_block(blk_a, 0);
        begin
            int t;
            t = 0;
            while (!eng_req && t < 100) begin
                @(negedge clk);
                t++;
            end
        end
        check("R12 req raised", 32'(eng_req), 32'd1);
        idle(3);
        check("R12 req held", 32'(eng_req), 32'd1);
        cfg_en = 1'b0;
        @(negedge clk);
        check("R10 req dropped", 32'(eng_req), 32'd0);
        check("R10 in flushed", 32'(sts_in_empty), 32'd1);
        idle(80);
        check("R10 no result", 32'(req_count - base), 32'd0);
        check("R10 out empty", 32'(sts_out_not_empty), 32'd0);

        // R10 writes while disabled are ignored
        write_word(32'h5555_5555);
        write_word(32'h6666_6666);
        @(negedge clk);
        cfg_en = 1'b1;
        eng_delay = 1;
        idle(2);
        check("R10 disabled write ignored", 32'(sts_in_empty), 32'd1);
        check("R10 disabled write no err", 32'(sts_err), 32'd0);
        write_block(blk_b, 0);
        read_block("R10 clean restart", cipher_f(blk_b, 2'b10, 1'b0));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule